// File: doc/BRIEF.md
# Two-Instruction 64-bit Execution Core

This block is a single-issue 64-bit integer core that understands only two instruction encodings: add-immediate (ADDI) and load doubleword (LD). It shows its program counter on an instruction port, takes the 32-bit instruction word that comes back in the same cycle, and decodes it. It reads one source register from a 32-entry file, forms a sum, and writes the result to a destination register. Register 0 always reads as zero.

An ADDI completes in one cycle. An LD sends its address through a valid/ready request channel. The core then waits for a response strobe that carries a 64-bit little-endian word, and writes that word to the register file in the cycle after the response. Any other instruction word raises a sticky illegal-instruction flag. Fetching then stops until reset.

Top module: `rv_mini_core`

## Requirements
- R1: A synchronous active-high reset clears the PC and all 32 registers to zero, drops the illegal flag and drops the load request.
- R2: Register index 0 is read as zero in every case.
- R3: A write whose destination index is 0, from either ADDI or LD, is discarded.
- R4: A word with bits [6:0] = 0010011 and bits [14:12] = 000 is ADDI. It writes rd (bits [11:7]) with rs1 (bits [19:15]) plus the immediate in bits [31:20] sign-extended to 64 bits. The sum wraps modulo 2^64.
- R5: A word with bits [6:0] = 0000011 and bits [14:12] = 011 is LD. One cycle after the word is presented, the core raises the request valid, with the address rs1 plus the sign-extended immediate.
- R6: After the request is accepted the core drops the request and waits for the response strobe for as long as needed. The PC does not move while it waits. The core writes the returned word to rd one cycle after the response.
- R7: The PC starts at 0 and advances by exactly 4 when each instruction completes: at the ADDI clock edge, or at the write-back edge of an LD.
- R8: Any other word, including other I-type ALU encodings and other load widths, sets a sticky illegal flag. From then on the PC is frozen and no load request is issued until reset.
- R9: While the request valid is high and ready is low, the request valid stays high and the address stays unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| imem_addr | output | 64 | Current PC, the address of the instruction being fetched |
| imem_word | input | 32 | Instruction word for the current PC |
| dmem_req_valid | output | 1 | Load request valid |
| dmem_req_ready | input | 1 | Memory accepts the load request |
| dmem_req_addr | output | 64 | Load byte address |
| dmem_rsp_valid | input | 1 | Load response strobe |
| dmem_rsp_data | input | 64 | Loaded 64-bit word, little-endian |
| illegal | output | 1 | Sticky illegal-instruction flag; the core is halted |

## Verification
The register file is observed only through load addresses. A corrupted register, a lost write or a write that reached register 0 therefore shows up on the address of the next LD that uses that register as its base. The bench builds chains of dependent ADDI and LD instructions so that every such fault reaches the port within a few instructions. A fault in the sequencer shows within one cycle: an extra or missing PC step, a request that drops early, or a write-back that skips its wait. The bench checks the PC at every instruction boundary and checks the request lines cycle by cycle while they stall.

// File: rtl/core_pkg.sv
package core_pkg;
    localparam int XLEN_DEF = 64;
    localparam int ILEN     = 32;
    localparam int REG_AW   = 5;
    localparam int IMM_W    = 12;

    localparam logic [6:0] OPC_OPIMM = 7'b0010011;
    localparam logic [6:0] OPC_LOAD  = 7'b0000011;
    localparam logic [2:0] F3_ADD    = 3'b000;
    localparam logic [2:0] F3_DWORD  = 3'b011;

    typedef enum logic [1:0] {
        OP_ADDI,
        OP_LD,
        OP_BAD
    } op_e;

    typedef enum logic [2:0] {
        ST_EXEC,
        ST_REQ,
        ST_WAIT,
        ST_WB,
        ST_HALT
    } state_e;

    typedef struct packed {
        op_e               op;
        logic [REG_AW-1:0] rd;
        logic [REG_AW-1:0] rs1;
        logic [IMM_W-1:0]  imm;
    } dec_t;

    function automatic logic [XLEN_DEF-1:0] sext_imm(input logic [IMM_W-1:0] v);
        return {{(XLEN_DEF-IMM_W){v[IMM_W-1]}}, v};
    endfunction
endpackage

// File: rtl/core_decoder.sv
module core_decoder
    import core_pkg::*;
(
    input  logic [ILEN-1:0] instr,
    output dec_t            dec
);
    logic [6:0] opcode;
    logic [2:0] funct3;

    assign opcode = instr[6:0];
    assign funct3 = instr[14:12];

    always_comb begin
        dec.rd  = instr[11:7];
        dec.rs1 = instr[19:15];
        dec.imm = instr[31:20];
        if (opcode == OPC_OPIMM && funct3 == F3_ADD) begin
            dec.op = OP_ADDI;
        end else if (opcode == OPC_LOAD && funct3 == F3_DWORD) begin
            dec.op = OP_LD;
        end else begin
            dec.op = OP_BAD;
        end
    end
endmodule

// File: rtl/core_regfile.sv
module core_regfile #(
    parameter int XLEN  = 64,
    parameter int NREGS = 32,
    localparam int AW   = $clog2(NREGS)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [AW-1:0]   ra,
    output logic [XLEN-1:0] rdata,
    input  logic            we,
    input  logic [AW-1:0]   wa,
    input  logic [XLEN-1:0] wdata
);
    // Entry 0 has no storage; entries 1..NREGS-1 are flops.
    logic [XLEN-1:0] ram [1:NREGS-1];

    for (genvar g = 1; g < NREGS; g++) begin : g_entry
        always_ff @(posedge clk) begin
            if (rst) begin
                ram[g] <= '0;
            end else if (we && wa == AW'(g)) begin
                ram[g] <= wdata;
            end
        end
    end

    assign rdata = (ra == '0) ? '0 : ram[ra];
endmodule

// File: rtl/rv_mini_core.sv
module rv_mini_core
    import core_pkg::*;
#(
    parameter int XLEN  = XLEN_DEF,
    parameter int NREGS = 1 << REG_AW
) (
    input  logic            clk,
    input  logic            rst,
    output logic [XLEN-1:0] imem_addr,
    input  logic [ILEN-1:0] imem_word,
    output logic            dmem_req_valid,
    input  logic            dmem_req_ready,
    output logic [XLEN-1:0] dmem_req_addr,
    input  logic            dmem_rsp_valid,
    input  logic [XLEN-1:0] dmem_rsp_data,
    output logic            illegal
);
    localparam logic [XLEN-1:0] PC_STEP = XLEN'(4);

    state_e            state_q;
    logic [XLEN-1:0]   pc_q;
    logic [XLEN-1:0]   addr_q;
    logic [XLEN-1:0]   data_q;
    logic [REG_AW-1:0] rd_q;

    dec_t              dec;
    logic [XLEN-1:0]   rs1_val;
    logic [XLEN-1:0]   sum;
    logic              rf_we;
    logic [REG_AW-1:0] rf_wa;
    logic [XLEN-1:0]   rf_wd;

    core_decoder u_dec (
        .instr (imem_word),
        .dec   (dec)
    );

    core_regfile #(.XLEN(XLEN), .NREGS(NREGS)) u_rf (
        .clk   (clk),
        .rst   (rst),
        .ra    (dec.rs1),
        .rdata (rs1_val),
        .we    (rf_we),
        .wa    (rf_wa),
        .wdata (rf_wd)
    );

    assign sum = rs1_val + sext_imm(dec.imm);

    always_comb begin
        rf_we = 1'b0;
        rf_wa = dec.rd;
        rf_wd = sum;
        if (state_q == ST_EXEC && dec.op == OP_ADDI) begin
            rf_we = 1'b1;
        end else if (state_q == ST_WB) begin
            rf_we = 1'b1;
            rf_wa = rd_q;
            rf_wd = data_q;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_EXEC;
            pc_q    <= '0;
            addr_q  <= '0;
            data_q  <= '0;
            rd_q    <= '0;
        end else begin
            unique case (state_q)
                ST_EXEC: begin
                    unique case (dec.op)
                        OP_ADDI: pc_q <= pc_q + PC_STEP;
                        OP_LD: begin
                            addr_q  <= sum;
                            rd_q    <= dec.rd;
                            state_q <= ST_REQ;
                        end
                        default: state_q <= ST_HALT;
                    endcase
                end
                ST_REQ: if (dmem_req_ready) state_q <= ST_WAIT;
                ST_WAIT: begin
                    if (dmem_rsp_valid) begin
                        data_q  <= dmem_rsp_data;
                        state_q <= ST_WB;
                    end
                end
                ST_WB: begin
                    pc_q    <= pc_q + PC_STEP;
                    state_q <= ST_EXEC;
                end
                default: state_q <= ST_HALT;
            endcase
        end
    end

    assign imem_addr      = pc_q;
    assign dmem_req_valid = (state_q == ST_REQ);
    assign dmem_req_addr  = addr_q;
    assign illegal        = (state_q == ST_HALT);

    AST_PC_STEP: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && (pc_q != $past(pc_q))) |-> (pc_q == $past(pc_q) + PC_STEP)); // R7

    AST_HALT_FROZEN: assert property (@(posedge clk) disable iff (rst)
        illegal |=> (illegal && $stable(pc_q) && !dmem_req_valid)); // R8

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
        (dmem_req_valid && !dmem_req_ready) |=> (dmem_req_valid && $stable(dmem_req_addr))); // R9

    AST_WB_AFTER_RSP: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_WB) |-> ($past(dmem_rsp_valid) && !dmem_req_valid)); // R6
endmodule

// File: tb/test_rv_mini_core.sv
`timescale 1ns/1ps
module test_rv_mini_core;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [63:0] imem_addr;
    logic [31:0] imem_word = 32'h0;
    logic        dmem_req_valid;
    logic        dmem_req_ready = 1'b0;
    logic [63:0] dmem_req_addr;
    logic        dmem_rsp_valid = 1'b0;
    logic [63:0] dmem_rsp_data = 64'h0;
    logic        illegal;

    int n_chk = 0;
    int n_bad = 0;
    logic [63:0] mdl [32];
    logic [63:0] exp_pc;

    always #5 clk = ~clk;

    rv_mini_core i_rv_mini_core (
        .clk(clk), .rst(rst),
        .imem_addr(imem_addr), .imem_word(imem_word),
        .dmem_req_valid(dmem_req_valid), .dmem_req_ready(dmem_req_ready),
        .dmem_req_addr(dmem_req_addr),
        .dmem_rsp_valid(dmem_rsp_valid), .dmem_rsp_data(dmem_rsp_data),
        .illegal(illegal)
    );

    function automatic logic [31:0] i_addi(input int rd, input int rs1, input int imm);
        logic [31:0] v;
        v = {imm[11:0], rs1[4:0], 3'b000, rd[4:0], 7'b0010011};
        return v;
    endfunction

    function automatic logic [31:0] i_ld(input int rd, input int rs1, input int imm);
        logic [31:0] v;
        v = {imm[11:0], rs1[4:0], 3'b011, rd[4:0], 7'b0000011};
        return v;
    endfunction

    // entry: {word, ready delay, response delay, load data}
    localparam int N = 12;
    localparam logic [103:0] PROG [N] = '{
        {i_addi(1, 0, 100),   4'd0, 4'd0, 64'h0},                  // R4
        {i_addi(2, 1, -1),    4'd0, 4'd0, 64'h0},                  // R4 negative imm
        {i_ld(3, 2, 8),       4'd0, 4'd0, 64'h0123_4567_89AB_CDEF}, // R5
        {i_addi(4, 3, 2047),  4'd0, 4'd0, 64'h0},                  // R4
        {i_ld(5, 4, -2048),   4'd3, 4'd2, 64'hFFFF_FFFF_FFFF_FFFF}, // R6 R9 stalls
        {i_addi(6, 5, 1),     4'd0, 4'd0, 64'h0},                  // R4 wrap
        {i_addi(0, 4, 5),     4'd0, 4'd0, 64'h0},                  // R3
        {i_ld(7, 0, 0),       4'd0, 4'd0, 64'h0000_0000_0000_0055}, // R2
        {i_ld(8, 6, 0),       4'd0, 4'd0, 64'h0000_0000_0000_1234}, // wrap seen
        {i_ld(9, 4, 16),      4'd1, 4'd0, 64'hDEAD_BEEF_0000_0010},
        {i_ld(0, 7, 0),       4'd0, 4'd0, 64'h0000_0000_0000_FFFF}, // R3 via LD
        {i_ld(10, 0, 0),      4'd0, 4'd1, 64'h0000_0000_0000_0AAA}  // R2 R3
    };

    task automatic chk(input logic ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [63:0] rdm(input logic [4:0] i);
        return (i == 5'd0) ? 64'h0 : mdl[i];
    endfunction

    // Called at a negedge with the core ready to execute.
    task automatic run_instr(input logic [103:0] e);
        logic [31:0] w;
        logic [63:0] sx, ea;
        w  = e[103:72];
        sx = {{52{w[31]}}, w[31:20]};
        chk(imem_addr == exp_pc, "R7 pc at fetch", imem_addr, exp_pc);
        imem_word = w;
        if (w[6:0] == 7'b0010011 && w[14:12] == 3'b000) begin
            if (w[11:7] != 5'd0) mdl[w[11:7]] = rdm(w[19:15]) + sx;
            exp_pc += 64'd4;
            @(negedge clk);
        end else begin
            ea = rdm(w[19:15]) + sx;
            @(negedge clk);
            chk(dmem_req_valid && dmem_req_addr == ea, "R4 R5 load address", dmem_req_addr, ea);
            for (int k = 0; k < int'(e[71:68]); k++) begin
                @(negedge clk);
                chk(dmem_req_valid && dmem_req_addr == ea, "R9 request held", dmem_req_addr, ea);
            end
            dmem_req_ready = 1'b1;
            @(negedge clk);
            dmem_req_ready = 1'b0;
            chk(!dmem_req_valid, "R6 request dropped", 64'(dmem_req_valid), 64'h0);
            for (int k = 0; k < int'(e[67:64]); k++) begin
                @(negedge clk);
                chk(imem_addr == exp_pc, "R6 pc still while waiting", imem_addr, exp_pc);
            end
            dmem_rsp_valid = 1'b1;
            dmem_rsp_data  = e[63:0];
            @(negedge clk);
            dmem_rsp_valid = 1'b0;
            dmem_rsp_data  = ~e[63:0];
            chk(imem_addr == exp_pc, "R6 pc held in write-back", imem_addr, exp_pc);
            @(negedge clk);
            if (w[11:7] != 5'd0) mdl[w[11:7]] = e[63:0];
            exp_pc += 64'd4;
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (2) @(negedge clk);
        chk(imem_addr == 64'h0, "R1 pc cleared", imem_addr, 64'h0);
        chk(!illegal, "R1 illegal cleared", 64'(illegal), 64'h0);
        chk(!dmem_req_valid, "R1 no request", 64'(dmem_req_valid), 64'h0);
        rst = 1'b0;
        for (int i = 0; i < 32; i++) mdl[i] = 64'h0;
        exp_pc = 64'h0;
    endtask

    task automatic expect_illegal(input logic [31:0] w);
        logic [63:0] pc0;
        pc0 = imem_addr;
        imem_word = w;
        @(negedge clk);
        chk(illegal, "R8 illegal raised", 64'(illegal), 64'h1);
        imem_word = i_addi(1, 0, 7);
        repeat (4) begin
            @(negedge clk);
            chk(!dmem_req_valid, "R8 no request when halted", 64'(dmem_req_valid), 64'h0);
        end
        chk(illegal && imem_addr == pc0, "R8 sticky halt, pc frozen", imem_addr, pc0);
    endtask

    initial begin
        #1_000_000;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        @(negedge clk);
        do_reset();
        for (int i = 0; i < N; i++) run_instr(PROG[i]);
        // R8: another I-type ALU operation (funct3 100) is not executed
        expect_illegal({12'd5, 5'd1, 3'b100, 5'd2, 7'b0010011});
        do_reset();
        // R1: x9 held a non-zero value before reset; now base reads zero
        run_instr({i_ld(1, 9, 0), 4'd0, 4'd0, 64'h77});
        run_instr({i_addi(2, 1, -5), 4'd0, 4'd0, 64'h0});
        run_instr({i_ld(3, 2, 0), 4'd2, 4'd3, 64'h1});
        // R8: a narrower load width (funct3 010) is undecodable
        expect_illegal({12'd0, 5'd2, 3'b010, 5'd3, 7'b0000011});
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule